// File: doc/BRIEF.md
# Offset-Preloaded BCD Frequency Counter

This block measures the local-oscillator frequency of a superheterodyne receiver and yields the tuned station frequency as four BCD digits in whole kilohertz. The raw, already squared-up oscillator signal is synchronised to the system clock. Its rising edges are counted by a prescaler that issues one count step for every `PRESCALE` edges, 500 by default. Those steps drive a chain of four decimal decades.

The intermediate frequency is removed without a subtractor. On the preload strobe, the decades take the ten's complement of the IF setting, which is 10000 minus the setting. The first IF-worth of count steps carries the chain through 9999 to 0000. The carry out of the top decade is dropped, so whatever counts remain equal the tuned frequency. An external sequencer raises preload, then holds count-enable for a 500 ms gate, then latches the result. That sequencer, the display latch and the segment decoding are outside this block.

Top module: `kfc_counter`

## Requirements
- R1: While `rst_n` is low, `digits` reads 0000 and the prescaler phase is cleared.
- R2: In the cycle after `preload` is high, `digits` holds 10000 minus `offset` in BCD. The result is taken modulo 10000. For example, 0465 gives 9535, 0000 gives 0000 and 9999 gives 0001. Digit 0, the units, is in bits [3:0], and each higher digit sits four bits above the one below it.
- R3: Each count step adds one to the four-digit decimal value. Each decade runs 0 to 9 and carries into the next. A step from 9999 gives 0000, and that carry is discarded.
- R4: With `count_en` high, the value advances by exactly one for every `PRESCALE` synchronised rising edges of `osc_in`. The default is 500.
- R5: While `count_en` is low, rising edges of `osc_in` have no effect. Neither `digits` nor the prescaler phase changes.
- R6: `preload` has priority over counting in any cycle where both could act. It also returns the prescaler phase to zero, so every gate starts from the same phase.
- R7: After a preload with setting F and then N×`PRESCALE` counted edges, `digits` equals N−F modulo 10000. With a 500 ms gate and the default divide, this is the tuned frequency in kHz.
- R8: `osc_in` passes through a two-flop synchroniser. Each rising edge counts once, however long the input then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_in | input | 1 | Conditioned oscillator pulse train, asynchronous to `clk` |
| preload | input | 1 | Loads the complement of `offset` and clears the prescaler |
| count_en | input | 1 | Gate: counting happens only while high |
| offset | input | 4×NDIG (16) | IF setting as BCD digits, units digit in bits [3:0] |
| digits | output | 4×NDIG (16) | Count value as BCD digits, units digit in bits [3:0] |

## Verification
Preload and counting can both act in the same cycle. A synchronised edge can complete a prescaler period while the strobe is high. The bench provokes this in two ways. In the first, it holds `preload` and `count_en` high together while pulsing `osc_in`, and expects `digits` to stay at the complement. In the second, it preloads again part-way through a prescaler period. It then shows that a full `PRESCALE` edges are still needed for the next step, which proves the phase was cleared. Assertions check the same priority cycle by cycle, and they also check the complement value and the single decimal step.

// File: rtl/kfc_pkg.sv
package kfc_pkg;
  localparam int DIG_W = 4;
  typedef logic [DIG_W-1:0] bcd_t;

  // one decade: add a carry-in, return {carry_out, sum}
  function automatic logic [DIG_W:0] bcd_add1(input bcd_t d, input logic cin);
    logic [DIG_W:0] r;
    if (cin && d == 4'd9) r = {1'b1, 4'd0};
    else if (cin)         r = {1'b0, d + 4'd1};
    else                  r = {1'b0, d};
    return r;
  endfunction

  function automatic bcd_t nines(input bcd_t d);
    return 4'd9 - d;
  endfunction
endpackage

// File: rtl/kfc_edge_sync.sv
module kfc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic s1, s2, s3;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end
  assign rise = s2 & ~s3;
endmodule

// File: rtl/kfc_prescaler.sv
module kfc_prescaler #(
  parameter int PRESCALE = 500,
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  output logic          tick,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  assign tick = advance && (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (clear)   phase <= '0;
    else if (tick)    phase <= '0;
    else if (advance) phase <= phase + 1'b1;
  end
endmodule

// File: rtl/kfc_decade.sv
module kfc_decade
  import kfc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  bcd_t load_val,
  input  logic cin,
  output bcd_t q,
  output logic cout
);
  logic [DIG_W:0] nxt;
  assign nxt  = bcd_add1(q, cin);
  assign cout = nxt[DIG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (cin)  q <= nxt[DIG_W-1:0];
  end
endmodule

// File: rtl/kfc_counter.sv
module kfc_counter
  import kfc_pkg::*;
#(
  parameter int NDIG     = 4,
  parameter int PRESCALE = 500,
  localparam int VW = NDIG * DIG_W,
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_in,
  input  logic          preload,
  input  logic          count_en,
  input  logic [VW-1:0] offset,
  output logic [VW-1:0] digits
);
  // named internal events for the checker
  logic          edge_pulse;
  logic          advance;
  logic          tick;
  logic [PW-1:0] pre_cnt;
  logic [VW-1:0] load_val;
  logic [NDIG:0] cchain;   // count carry chain
  logic [NDIG:0] kchain;   // complement +1 carry chain

  kfc_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(osc_in), .rise(edge_pulse)
  );

  assign advance = edge_pulse && count_en && !preload;

  kfc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(preload), .advance(advance),
    .tick(tick), .phase(pre_cnt)
  );

  assign cchain[0] = tick;
  assign kchain[0] = 1'b1;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [DIG_W:0] csum;
    assign csum = bcd_add1(nines(offset[i*DIG_W +: DIG_W]), kchain[i]);
    assign load_val[i*DIG_W +: DIG_W] = csum[DIG_W-1:0];
    assign kchain[i+1] = csum[DIG_W];

    kfc_decade u_dec (
      .clk(clk), .rst_n(rst_n), .load(preload),
      .load_val(load_val[i*DIG_W +: DIG_W]),
      .cin(cchain[i]),
      .q(digits[i*DIG_W +: DIG_W]),
      .cout(cchain[i+1])
    );
  end
endmodule

// File: rtl/kfc_assert.sv
module kfc_assert #(
  parameter int NDIG     = 4,
  parameter int PRESCALE = 500,
  localparam int VW = NDIG * 4,
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          preload,
  input logic          count_en,
  input logic [VW-1:0] offset,
  input logic [VW-1:0] digits,
  input logic          edge_pulse,
  input logic          tick,
  input logic [PW-1:0] pre_cnt
);
  function automatic int to_int(input logic [VW-1:0] v);
    int r = 0;
    for (int i = NDIG - 1; i >= 0; i--) r = r * 10 + int'(v[i*4 +: 4]);
    return r;
  endfunction

  function automatic logic [VW-1:0] to_bcd(input int n);
    logic [VW-1:0] r = '0;
    int x = n;
    for (int i = 0; i < NDIG; i++) begin
      r[i*4 +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic int modulus();
    int m = 1;
    for (int i = 0; i < NDIG; i++) m = m * 10;
    return m;
  endfunction

  AST_PRELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    preload |=> digits == to_bcd((modulus() - to_int($past(offset))) % modulus())); // R2
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> digits == to_bcd((to_int($past(digits)) + 1) % modulus())); // R3
  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> edge_pulse && count_en); // R4
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pre_cnt) < PRESCALE); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en && !preload |=> $stable(digits) && $stable(pre_cnt)); // R5
  AST_PRELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    preload |-> !tick); // R6
  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    preload |=> pre_cnt == '0); // R6
endmodule

bind kfc_counter kfc_assert #(.NDIG(NDIG), .PRESCALE(PRESCALE)) u_kfc_assert (
  .clk(clk), .rst_n(rst_n), .preload(preload), .count_en(count_en),
  .offset(offset), .digits(digits), .edge_pulse(edge_pulse),
  .tick(tick), .pre_cnt(pre_cnt)
);

// File: tb/tb_kfc_counter.sv
`timescale 1ns/1ps
module tb_kfc_counter;
  localparam int PS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_in = 1'b0;
  logic        preload = 1'b0;
  logic        count_en = 1'b0;
  logic [15:0] offset = '0;
  logic [15:0] digits;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  kfc_counter #(.NDIG(4), .PRESCALE(PS)) dut (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .preload(preload),
    .count_en(count_en), .offset(offset), .digits(digits)
  );

  // bench model: decimal BCD arithmetic written independently
  function automatic logic [15:0] mk(input int n);
    int x = ((n % 10000) + 10000) % 10000;
    return {4'(x / 1000), 4'((x / 100) % 10), 4'((x / 10) % 10), 4'(x % 10)};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: digits=%h expected %h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n, input int high = 3);
    for (int i = 0; i < n; i++) begin
      osc_in = 1'b1; clocks(high);
      osc_in = 1'b0; clocks(3);
    end
    clocks(2);
  endtask

  task automatic do_preload(input logic [15:0] off);
    offset = off;
    preload = 1'b1; clocks(1);
    preload = 1'b0; clocks(1);
  endtask

  task automatic t_reset();
    clocks(1);
    check("R1 reset", digits, 16'h0000);
  endtask

  task automatic t_preload();
    do_preload(16'h0465); check("R2 offset 0465", digits, 16'h9535);
    do_preload(16'h0000); check("R2 offset 0000", digits, 16'h0000);
    do_preload(16'h9999); check("R2 offset 9999", digits, 16'h0001);
  endtask

  task automatic t_prescale();
    count_en = 1'b1;
    do_preload(16'h0000);
    pulses(PS - 1); check("R4 short of period", digits, 16'h0000);
    pulses(1);      check("R4 full period", digits, 16'h0001);
    pulses(2 * PS); check("R4 two periods", digits, 16'h0003);
  endtask

  task automatic t_long_high();
    do_preload(16'h0000);
    pulses(PS, 20); check("R8 long high counts once", digits, 16'h0001);
  endtask

  task automatic t_hold();
    do_preload(16'h0000);
    count_en = 1'b0;
    pulses(2 * PS + 2); check("R5 gate closed", digits, 16'h0000);
    count_en = 1'b1;
    pulses(PS - 1); check("R5 phase untouched", digits, 16'h0000);
    pulses(1);      check("R5 resumes", digits, 16'h0001);
  endtask

  task automatic t_rollover();
    do_preload(16'h0001);
    pulses(PS); check("R3 9999 wraps", digits, 16'h0000);
    do_preload(16'h8001);
    pulses(PS); check("R3 inner carries", digits, 16'h2000);
    do_preload(16'h0010);
    pulses(PS); check("R3 units carry", digits, 16'h9991);
  endtask

  task automatic t_priority();
    count_en = 1'b1;
    offset = 16'h0465;
    preload = 1'b1;
    pulses(2 * PS);
    preload = 1'b0; clocks(1);
    check("R6 preload held over edges", digits, 16'h9535);
    do_preload(16'h0000);
    pulses(PS - 1);
    do_preload(16'h0000);
    pulses(PS - 1); check("R6 phase cleared", digits, 16'h0000);
    pulses(1);      check("R6 full period after reload", digits, 16'h0001);
  endtask

  task automatic t_measure();
    count_en = 1'b1;
    do_preload(16'h0465);
    pulses(470 * PS);
    count_en = 1'b0; clocks(2);
    check("R7 470 minus 465", digits, mk(470 - 465));
    count_en = 1'b1;
    do_preload(16'h0010);
    pulses(35 * PS);
    check("R7 35 minus 10", digits, mk(35 - 10));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clocks(3);
    check("R1 in reset", digits, 16'h0000);
    rst_n = 1'b1;
    t_reset();
    t_preload();
    t_prescale();
    t_long_high();
    t_hold();
    t_rollover();
    t_priority();
    t_measure();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule